// File: doc/BRIEF.md
# LPC DMA Peripheral Transfer Agent

This block is the device side of DMA cycles on a 4-bit multiplexed LPC bus. It watches the host nibbles and spots a start marker followed by a DMA cycle type. It then stores the channel number and the terminal-count flag, and decodes the transfer size. After that it moves one or two bytes, low nibble first. On a host-to-device transfer (read) it takes in nibbles from the bus. On a device-to-host transfer (write or verify) it drives nibbles onto the bus.

For every byte the agent returns a SYNC nibble to the host. That nibble either ends the transfer or asks for more data. The device core sets the choice through two level inputs, `core_err` and `core_more`. The agent never ends a transfer by any other means.

The core sees a simple local interface. Read bytes arrive with a one-cycle valid pulse. Write bytes are sampled from a data input, and a take pulse acknowledges each one. The stored terminal count comes back as a one-cycle pulse, and only on the final byte of the sized transfer.

Top module: `ldma_agent`

## Requirements
- R1: After a synchronous reset, `lpc_oe`, `core_rvalid`, `core_take`, `core_tc` and `size_bad` are all 0.
- R2: A cycle begins when `lpc_frame`=1 and `lpc_in`=0000. The next nibble selects the cycle type. Bits [3:2]=10 mark a DMA cycle. Bit 1 gives the direction: 1 = write, which also covers verify, and 0 = read. Any other type is ignored: the bus is not driven and no core strobe fires.
- R3: The third nibble carries the channel number in bits [2:0], which appear on `dma_chan`, and the terminal-count flag in bit 3. `core_tc` pulses only when that flag was set and the last byte of the sized transfer moves. It never pulses on a byte that ends the transfer early.
- R4: The size nibble sets the byte count from bits [1:0]: 00 means 1 byte and 01 means 2 bytes. Any other value is moved as 1 byte, and `size_bad` stays at 1 until the next start.
- R5: The SYNC nibble for a byte is 1010 if `core_err`=1. Otherwise it is 1001 if `core_more`=1, and 0000 if neither is set.
- R6: A 0000 or 1010 SYNC ends the transfer after that byte, so a 2-byte transfer can stop after its first byte. A 1001 SYNC on a byte that is not the last one lets the next byte follow. Even with 1001, no byte follows the last byte of the size.
- R7: Read timing. The two data nibbles arrive in the two cycles after the size nibble, low nibble first. `core_rvalid` then pulses for one cycle with the assembled byte on `core_rdata`. SYNC is driven for one cycle, starting TAR_CYC cycles after that pulse. The bus is then released, and the next byte's low nibble comes TAR_CYC+1 cycles after SYNC.
- R8: Write timing. SYNC is driven TAR_CYC cycles after the size nibble, and `core_take` pulses in the same cycle. `core_wdata` is sampled at that point. Its low nibble is then driven, followed by its high nibble. After that the agent drives the next SYNC or releases the bus.
- R9: A start marker in any state aborts the current cycle, and the byte count of the new cycle starts again from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lpc_frame | input | 1 | Host frame marker, active high |
| lpc_in | input | 4 | Nibble driven by the host |
| lpc_out | output | 4 | Nibble driven by the agent |
| lpc_oe | output | 1 | Agent drives the bus |
| core_wdata | input | DATA_W | Byte to send on a write |
| core_more | input | 1 | Core asks for more data |
| core_err | input | 1 | Core reports an error |
| core_take | output | 1 | Write byte sampled |
| core_rdata | output | DATA_W | Byte received on a read |
| core_rvalid | output | 1 | Read byte valid pulse |
| core_tc | output | 1 | Terminal-count pulse |
| dma_chan | output | CHAN_W | Stored channel number |
| size_bad | output | 1 | Unsupported size seen |

## Verification
The assertions rely on two things about the inputs. The host raises `lpc_frame` only together with a start nibble. The core holds `core_err` and `core_more` steady across the edge where a SYNC is chosen. The bench meets both conditions by changing every input at falling edges. It keeps `lpc_frame` low for the whole transfer except when it deliberately restarts mid-cycle. It also loads the core inputs for each byte before that byte's SYNC edge.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CYC, ST_CHAN, ST_SIZE, ST_RDAT,
    ST_TARA, ST_SYNC, ST_TARB, ST_WDAT
  } ldma_st_t;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [1:0] TYPE_DMA  = 2'b10;
  localparam logic [3:0] SY_DONE   = 4'b0000;
  localparam logic [3:0] SY_ERR    = 4'b1010;
  localparam logic [3:0] SY_MORE   = 4'b1001;
endpackage

// File: rtl/ldma_hdr.sv
module ldma_hdr #(
  parameter int CHAN_W  = 3,
  parameter int CNT_W   = 2,
  parameter bit WORD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cap_chan,
  input  logic              cap_size,
  input  logic [3:0]        nib,
  output logic [CHAN_W-1:0] chan_o,
  output logic              tc_o,
  output logic [CNT_W-1:0]  nbytes_o,
  output logic              size_bad_o
);
  localparam int TC_BIT = CHAN_W;

  logic [CNT_W-1:0] dec_n;
  logic             dec_bad;

  generate
    if (WORD_EN) begin : g_word
      always_comb begin
        case (nib[1:0])
          2'b00:   begin dec_n = CNT_W'(1); dec_bad = 1'b0; end
          2'b01:   begin dec_n = CNT_W'(2); dec_bad = 1'b0; end
          default: begin dec_n = CNT_W'(1); dec_bad = 1'b1; end
        endcase
      end
    end else begin : g_byte
      always_comb begin
        dec_n   = CNT_W'(1);
        dec_bad = (nib[1:0] != 2'b00);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_o     <= '0;
      tc_o       <= 1'b0;
      nbytes_o   <= CNT_W'(1);
      size_bad_o <= 1'b0;
    end else if (clr) begin
      tc_o       <= 1'b0;
      nbytes_o   <= CNT_W'(1);
      size_bad_o <= 1'b0;
    end else begin
      if (cap_chan) begin
        chan_o <= nib[CHAN_W-1:0];
        tc_o   <= nib[TC_BIT];
      end
      if (cap_size) begin
        nbytes_o   <= dec_n;
        size_bad_o <= dec_bad;
      end
    end
  end

  // R4: byte count is always one or two
  a_r4_size_range: assert property (@(posedge clk) disable iff (rst)
    (nbytes_o == CNT_W'(1)) || (nbytes_o == CNT_W'(2)));

  // R4: a bad size is moved as a single byte
  a_r4_bad_single: assert property (@(posedge clk) disable iff (rst)
    size_bad_o |-> (nbytes_o == CNT_W'(1)));
endmodule

// File: rtl/ldma_sync_sel.sv
module ldma_sync_sel (
  input  logic       err,
  input  logic       more,
  input  logic       last,
  output logic [3:0] code,
  output logic       ends
);
  import ldma_pkg::*;

  always_comb begin
    if (err)       code = SY_ERR;
    else if (more) code = SY_MORE;
    else           code = SY_DONE;
    ends = err | ~more | last;
  end
endmodule

// File: rtl/ldma_nibq.sv
module ldma_nibq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  input  logic [3:0]        nin,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {nin, q[DATA_W-1:4]};
  end
endmodule

// File: rtl/ldma_agent.sv
module ldma_agent #(
  parameter int CHAN_W  = 3,
  parameter int DATA_W  = 8,
  parameter int TAR_CYC = 2,
  parameter bit WORD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lpc_frame,
  input  logic [3:0]        lpc_in,
  output logic [3:0]        lpc_out,
  output logic              lpc_oe,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              core_more,
  input  logic              core_err,
  output logic              core_take,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_rvalid,
  output logic              core_tc,
  output logic [CHAN_W-1:0] dma_chan,
  output logic              size_bad
);
  import ldma_pkg::*;

  localparam int NIBS  = DATA_W / 4;
  localparam int NW    = $clog2(NIBS + 1);
  localparam int TW    = (TAR_CYC > 1) ? $clog2(TAR_CYC) : 1;
  localparam int CNT_W = 2;

  ldma_st_t         state;
  logic             wr_q, end_q, last_q;
  logic [NW-1:0]    ncnt;
  logic [TW-1:0]    tcnt;
  logic [CNT_W-1:0] bcnt;
  logic [CNT_W-1:0] nbytes;
  logic             tc_q;
  logic             restart, is_last, tar_done;
  logic             sq_load, sq_shift;
  logic [3:0]       sel_code;
  logic             sel_ends;
  logic [DATA_W-1:0] sq;

  assign restart  = lpc_frame && (lpc_in == NIB_START);
  assign is_last  = (bcnt == nbytes - CNT_W'(1));
  assign tar_done = (tcnt == TW'(TAR_CYC - 1));

  ldma_hdr #(.CHAN_W(CHAN_W), .CNT_W(CNT_W), .WORD_EN(WORD_EN)) u_hdr (
    .clk(clk), .rst(rst), .clr(restart),
    .cap_chan(state == ST_CHAN), .cap_size(state == ST_SIZE),
    .nib(lpc_in), .chan_o(dma_chan), .tc_o(tc_q),
    .nbytes_o(nbytes), .size_bad_o(size_bad)
  );

  ldma_sync_sel u_sel (
    .err(core_err), .more(core_more), .last(is_last),
    .code(sel_code), .ends(sel_ends)
  );

  always_comb begin
    sq_load  = 1'b0;
    sq_shift = 1'b0;
    if (!restart) begin
      case (state)
        ST_TARA: sq_load  = wr_q && tar_done;
        ST_WDAT: begin
          sq_load  = (ncnt == NW'(NIBS)) && !end_q;
          sq_shift = (ncnt != NW'(NIBS));
        end
        ST_SYNC: sq_shift = wr_q;
        ST_RDAT: sq_shift = 1'b1;
        default: ;
      endcase
    end
  end

  ldma_nibq #(.DATA_W(DATA_W)) u_q (
    .clk(clk), .rst(rst), .load(sq_load), .shift(sq_shift),
    .din(core_wdata), .nin(lpc_in), .q(sq)
  );
  assign core_rdata = sq;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      wr_q        <= 1'b0;
      end_q       <= 1'b0;
      last_q      <= 1'b0;
      ncnt        <= '0;
      tcnt        <= '0;
      bcnt        <= '0;
      lpc_out     <= 4'hF;
      lpc_oe      <= 1'b0;
      core_take   <= 1'b0;
      core_rvalid <= 1'b0;
      core_tc     <= 1'b0;
    end else begin
      core_take   <= 1'b0;
      core_rvalid <= 1'b0;
      core_tc     <= 1'b0;
      if (restart) begin
        state  <= ST_CYC;
        lpc_oe <= 1'b0;
        bcnt   <= '0;
      end else begin
        case (state)
          ST_CYC: begin
            if (lpc_in[3:2] == TYPE_DMA) begin
              wr_q  <= lpc_in[1];
              state <= ST_CHAN;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_CHAN: state <= ST_SIZE;
          ST_SIZE: begin
            ncnt  <= '0;
            tcnt  <= '0;
            state <= wr_q ? ST_TARA : ST_RDAT;
          end
          ST_RDAT: begin
            ncnt <= ncnt + NW'(1);
            if (ncnt == NW'(NIBS - 1)) begin
              core_rvalid <= 1'b1;
              core_tc     <= tc_q && is_last;
              tcnt        <= '0;
              state       <= ST_TARA;
            end
          end
          ST_TARA: begin
            if (tar_done) begin
              state     <= ST_SYNC;
              lpc_oe    <= 1'b1;
              lpc_out   <= sel_code;
              end_q     <= sel_ends;
              last_q    <= is_last;
              core_take <= wr_q;
            end else begin
              tcnt <= tcnt + TW'(1);
            end
          end
          ST_SYNC: begin
            bcnt <= bcnt + CNT_W'(1);
            tcnt <= '0;
            if (wr_q) begin
              state   <= ST_WDAT;
              lpc_out <= sq[3:0];
              ncnt    <= NW'(1);
            end else begin
              lpc_oe <= 1'b0;
              state  <= end_q ? ST_IDLE : ST_TARB;
            end
          end
          ST_TARB: begin
            if (tar_done) begin
              ncnt  <= '0;
              state <= ST_RDAT;
            end else begin
              tcnt <= tcnt + TW'(1);
            end
          end
          ST_WDAT: begin
            if (ncnt != NW'(NIBS)) begin
              lpc_out <= sq[3:0];
              ncnt    <= ncnt + NW'(1);
            end else if (end_q) begin
              state   <= ST_IDLE;
              lpc_oe  <= 1'b0;
              core_tc <= tc_q && last_q;
            end else begin
              state     <= ST_SYNC;
              lpc_out   <= sel_code;
              end_q     <= sel_ends;
              last_q    <= is_last;
              core_take <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: the bus is never driven while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !lpc_oe);

  // R5: a SYNC nibble is one of the three legal codes
  a_r5_code_legal: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SYNC) |-> (lpc_oe &&
      (lpc_out == SY_DONE || lpc_out == SY_ERR || lpc_out == SY_MORE)));

  // R6: no byte beyond the transfer size
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SYNC) |-> (bcnt < nbytes));

  // R3: terminal count only with a completed byte
  a_r3_tc_with_byte: assert property (@(posedge clk) disable iff (rst)
    core_tc |-> (core_rvalid || (state == ST_IDLE)));

  // R7: read valid is a single-cycle pulse
  a_r7_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
    core_rvalid |=> !core_rvalid);

  // R8: write data is taken only while SYNC is on the bus
  a_r8_take_at_sync: assert property (@(posedge clk) disable iff (rst)
    core_take |-> ((state == ST_SYNC) && lpc_oe));
endmodule

// File: tb/ldma_agent_tb.sv
`timescale 1ns/1ps
module ldma_agent_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lpc_frame = 1'b0;
  logic [3:0] lpc_in = 4'hF;
  logic [3:0] lpc_out;
  logic       lpc_oe;
  logic [7:0] core_wdata = 8'h00;
  logic       core_more = 1'b0;
  logic       core_err = 1'b0;
  logic       core_take;
  logic [7:0] core_rdata;
  logic       core_rvalid;
  logic       core_tc;
  logic [2:0] dma_chan;
  logic       size_bad;

  always #2.5 clk = ~clk;

  ldma_agent u_dut (
    .clk(clk), .rst(rst), .lpc_frame(lpc_frame), .lpc_in(lpc_in),
    .lpc_out(lpc_out), .lpc_oe(lpc_oe), .core_wdata(core_wdata),
    .core_more(core_more), .core_err(core_err), .core_take(core_take),
    .core_rdata(core_rdata), .core_rvalid(core_rvalid), .core_tc(core_tc),
    .dma_chan(dma_chan), .size_bad(size_bad)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [3:0] c_out;
  logic       c_oe, c_take, c_rv, c_tc;
  logic [7:0] c_rd;

  // {dir, chan, tc, size, err0, more0, err1, more1, d0, d1, exp_n, exp_tc}
  localparam int NV = 8;
  localparam logic [29:0] TBL [0:NV-1] = '{
    {1'b0, 3'd2, 1'b1, 2'b00, 4'b0000, 8'h3C, 8'h00, 2'd1, 1'b1},
    {1'b0, 3'd5, 1'b0, 2'b01, 4'b0100, 8'h5A, 8'hC3, 2'd2, 1'b0},
    {1'b0, 3'd1, 1'b1, 2'b01, 4'b0000, 8'h81, 8'h00, 2'd1, 1'b0},
    {1'b0, 3'd7, 1'b1, 2'b01, 4'b0110, 8'h0F, 8'hF0, 2'd2, 1'b1},
    {1'b1, 3'd3, 1'b1, 2'b00, 4'b0100, 8'h96, 8'h00, 2'd1, 1'b1},
    {1'b1, 3'd6, 1'b1, 2'b01, 4'b0100, 8'hA5, 8'h7E, 2'd2, 1'b1},
    {1'b1, 3'd0, 1'b0, 2'b01, 4'b1000, 8'h42, 8'h00, 2'd1, 1'b0},
    {1'b1, 3'd4, 1'b1, 2'b10, 4'b0000, 8'hE1, 8'h00, 2'd1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    c_out = lpc_out; c_oe = lpc_oe; c_take = core_take;
    c_rv = core_rvalid; c_tc = core_tc; c_rd = core_rdata;
    lpc_frame = fr;
    lpc_in = nib;
  endtask

  task automatic send_hdr(input logic dir, input logic [2:0] ch,
                          input logic tc, input logic [1:0] sz);
    step(1'b1, 4'h0);
    step(1'b0, {2'b10, dir, 1'b0});
    step(1'b0, {tc, ch});
    step(1'b0, {2'b00, sz});
  endtask

  task automatic run_xfer(input logic dir, input logic [2:0] ch, input logic tc,
                          input logic [1:0] sz, input logic [3:0] em,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input int exp_n, input logic exp_tc);
    int nsz = (sz == 2'b01) ? 2 : 1;
    int moved = 0;
    logic seen_tc = 1'b0;
    core_err = em[3]; core_more = em[2]; core_wdata = d0;
    send_hdr(dir, ch, tc, sz);
    if (!dir) begin
      for (int k = 0; k < 2; k++) begin
        logic e = (k == 0) ? em[3] : em[1];
        logic m = (k == 0) ? em[2] : em[0];
        logic [7:0] d = (k == 0) ? d0 : d1;
        logic [3:0] code = e ? 4'hA : (m ? 4'h9 : 4'h0);
        logic lastsz = (k == nsz - 1);
        logic ends = e | !m | lastsz;
        core_err = e; core_more = m;
        step(1'b0, d[3:0]);
        step(1'b0, d[7:4]);
        step(1'b0, 4'hF);
        chk("R7 rvalid pulse", c_rv, 1);
        chk("R7 read byte low nibble first", c_rd, d);
        chk("R3 tc on read byte", c_tc, tc && lastsz);
        seen_tc |= c_tc;
        moved++;
        step(1'b0, 4'hF);
        step(1'b0, 4'hF);
        chk("R5 read sync drive", c_oe, 1);
        chk("R5 read sync code", c_out, code);
        step(1'b0, 4'hF);
        chk("R7 release after sync", c_oe, 0);
        step(1'b0, 4'hF);
        if (ends) break;
      end
      if (moved < nsz) begin
        logic stray = 1'b0;
        for (int j = 0; j < 4; j++) begin
          step(1'b0, 4'h6);
          stray |= c_rv | c_oe;
        end
        chk("R6 no second read byte", stray, 0);
      end
    end else begin
      step(1'b0, 4'hF);
      step(1'b0, 4'hF);
      for (int k = 0; k < 2; k++) begin
        logic e = (k == 0) ? em[3] : em[1];
        logic m = (k == 0) ? em[2] : em[0];
        logic [7:0] d = (k == 0) ? d0 : d1;
        logic [3:0] code = e ? 4'hA : (m ? 4'h9 : 4'h0);
        logic lastsz = (k == nsz - 1);
        logic ends = e | !m | lastsz;
        core_err = e; core_more = m; core_wdata = d;
        step(1'b0, 4'hF);
        chk("R8 write sync drive", c_oe, 1);
        chk("R5 write sync code", c_out, code);
        chk("R8 take with sync", c_take, 1);
        if (k > 0) chk("R3 no tc mid transfer", c_tc, 0);
        core_wdata = 8'h00;
        step(1'b0, 4'hF);
        chk("R8 write low nibble", c_out, d[3:0]);
        step(1'b0, 4'hF);
        chk("R8 write high nibble", c_out, d[7:4]);
        moved++;
        if (ends) begin
          step(1'b0, 4'hF);
          chk("R6 write release", c_oe, 0);
          chk("R3 tc on write end", c_tc, tc && lastsz);
          seen_tc |= c_tc;
          break;
        end
      end
    end
    chk("R6 bytes moved", moved, exp_n);
    chk("R3 tc seen", seen_tc, exp_tc);
    chk("R3 channel", dma_chan, ch);
    chk("R4 size flag", size_bad, (sz > 2'b01) ? 1 : 0);
    step(1'b0, 4'hF);
    step(1'b0, 4'hF);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    step(1'b0, 4'hF);
    chk("R1 reset oe", c_oe, 0);
    chk("R1 reset rvalid", c_rv, 0);
    chk("R1 reset take", c_take, 0);
    chk("R1 reset tc", c_tc, 0);
    chk("R1 reset size flag", size_bad, 0);

    for (int v = 0; v < NV; v++) begin
      logic [29:0] t = TBL[v];
      run_xfer(t[29], t[28:26], t[25], t[24:23], t[22:19],
               t[18:11], t[10:3], int'(t[2:1]), t[0]);
    end

    // R2: a non-DMA cycle type is ignored
    begin
      logic touched = 1'b0;
      step(1'b1, 4'h0);
      step(1'b0, 4'b0010);
      for (int j = 0; j < 8; j++) begin
        step(1'b0, 4'h5);
        touched |= c_oe | c_rv | c_take | c_tc;
      end
      chk("R2 non-DMA ignored", touched, 0);
    end

    // R9: restart after one byte of a 2-byte read
    core_err = 1'b0; core_more = 1'b1;
    send_hdr(1'b0, 3'd1, 1'b1, 2'b01);
    step(1'b0, 4'h7);
    step(1'b0, 4'h2);
    step(1'b0, 4'hF);
    chk("R9 first byte before restart", c_rd, 8'h27);
    step(1'b0, 4'hF);
    step(1'b0, 4'hF);
    step(1'b0, 4'hF);
    step(1'b0, 4'hF);
    run_xfer(1'b0, 3'd6, 1'b1, 2'b01, 4'b0100, 8'h11, 8'h22, 2, 1'b1);

    // R9: restart in the middle of a write header
    step(1'b1, 4'h0);
    step(1'b0, 4'b1010);
    run_xfer(1'b1, 3'd2, 1'b0, 2'b00, 4'b0000, 8'hB4, 8'h00, 1, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule